// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory and write-back. Each cycle the datapath presents the instruction sitting in decode: its source register numbers, flags saying which sources are really read, its destination, whether it writes a register, whether it is a load, and, for a branch, the taken/not-taken result of the decode-stage comparator. The controller keeps its own shadow copy of the destination and source fields of the instructions that have moved on into execute, memory and write-back. It compares the younger instructions' sources against the older instructions' destinations.

From those comparisons it produces the operand selects for the two ALU input multiplexers in execute and the operand selects for the branch comparator in decode. It also produces a stall that freezes the program counter and the fetch/decode register, a bubble that clears the control bits of the decode/execute register, and a squash that turns the sequentially fetched instruction into a no-op after a taken branch. Branches are predicted not taken and are resolved in decode, so a taken branch costs one cycle. The register file is written in the first half of a cycle and read in the second half, so a producer in write-back never needs a bypass into decode.

Top module: `hazard_fwd_unit`

## Requirements
- R1: After reset, with no instruction presented, both ALU selects read 00, both branch selects read 0, and stall, bubble and squash are all low.
- R2: ALU select encoding is 00 = register-file operand, 01 = result held in the execute/memory register, 10 = value held in the memory/write-back register. An instruction in execute whose source matches the destination of the instruction one ahead of it gets select 01, with no stall.
- R3: An instruction in execute whose source matches the destination in the memory/write-back register gets select 10. This holds for both operand A and operand B.
- R4: When the execute/memory and memory/write-back registers both hold a matching destination, the select is 01, so the younger result wins.
- R5: An instruction three positions behind its producer gets select 00, because it reads the newly written value from the register file.
- R6: A source in decode that matches the destination of a load now in execute raises stall and bubble for exactly one cycle. After that bubble, the consumer in execute gets select 10.
- R7: Register 0 never causes a stall or a nonzero select.
- R8: A producer whose write-enable is clear never causes a stall or a nonzero select.
- R9: A branch in decode with no pending dependency raises squash in the same cycle if it is taken, and leaves squash low if it is not taken.
- R10: A branch whose source matches an ALU result now in execute stalls one cycle. It then sees branch select 1, meaning the value is taken from the execute/memory register. A branch whose source matches a load now in execute stalls two cycles and then sees branch select 0.
- R11: A source field whose use flag is clear causes no stall and no nonzero select.
- R12: Squash is never raised in a cycle that stalls, and bubble is raised exactly when stall is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode holds a real instruction |
| id_rs1 | input | 5 | Decode source A register number |
| id_rs2 | input | 5 | Decode source B register number |
| id_use_rs1 | input | 1 | Source A is read |
| id_use_rs2 | input | 1 | Source B is read |
| id_rd | input | 5 | Decode destination register number |
| id_we | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Decode-stage branch comparator result |
| ex_fwd_a | output | 2 | ALU operand A select |
| ex_fwd_b | output | 2 | ALU operand B select |
| id_fwd_a | output | 1 | Branch comparator A takes the execute/memory result |
| id_fwd_b | output | 1 | Branch comparator B takes the execute/memory result |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Clear decode/execute control bits |
| squash | output | 1 | Turn fetched instruction into a no-op |

## Verification
The bench targets the ordering corners. When both later stages match, a design without the priority would hand the ALU a stale value with select 10. A producer three slots ahead must get select 00; a design that over-bypasses would show 10 or 01 there. The load-use case must stall exactly once and then bypass from write-back, and a branch behind a load must stall twice. A controller that counted wrongly would release a branch early, with a wrong select or a premature squash. Register 0, a clear write-enable and a clear use flag are each presented with otherwise matching numbers; a faulty design would stall or bypass on them.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_FILE  = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_sel_e;

  localparam int NSRC = 2;
endpackage

// File: rtl/hzd_rst_sync.sv
module hzd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/hzd_track.sv
module hzd_track #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     id_valid,
  input  logic                     id_we,
  input  logic                     id_load,
  input  logic [AW-1:0]            id_rd,
  input  logic [NSRC-1:0][AW-1:0]  id_rs,
  input  logic [NSRC-1:0]          id_use,
  input  logic                     bubble,
  output logic                     idex_we,
  output logic                     idex_load,
  output logic [AW-1:0]            idex_rd,
  output logic [NSRC-1:0][AW-1:0]  idex_rs,
  output logic [NSRC-1:0]          idex_use,
  output logic                     exmem_we,
  output logic                     exmem_load,
  output logic [AW-1:0]            exmem_rd,
  output logic                     memwb_we,
  output logic [AW-1:0]            memwb_rd
);
  logic                    idex_we_d, idex_load_d;
  logic [AW-1:0]           idex_rd_d;
  logic [NSRC-1:0][AW-1:0] idex_rs_d;
  logic [NSRC-1:0]         idex_use_d;
  logic                    adv_en;

  // The shadow pipeline moves every cycle; the enable is kept explicit.
  assign adv_en = 1'b1;

  always_comb begin
    idex_we_d   = id_valid & id_we & ~bubble;
    idex_load_d = id_valid & id_load & ~bubble;
    idex_rd_d   = id_rd;
    idex_rs_d   = id_rs;
    idex_use_d  = id_valid & ~bubble ? id_use : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_we    <= 1'b0;
      idex_load  <= 1'b0;
      idex_rd    <= '0;
      idex_rs    <= '0;
      idex_use   <= '0;
      exmem_we   <= 1'b0;
      exmem_load <= 1'b0;
      exmem_rd   <= '0;
      memwb_we   <= 1'b0;
      memwb_rd   <= '0;
    end else if (adv_en) begin
      idex_we    <= idex_we_d;
      idex_load  <= idex_load_d;
      idex_rd    <= idex_rd_d;
      idex_rs    <= idex_rs_d;
      idex_use   <= idex_use_d;
      exmem_we   <= idex_we;
      exmem_load <= idex_load;
      exmem_rd   <= idex_rd;
      memwb_we   <= exmem_we;
      memwb_rd   <= exmem_rd;
    end
  end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] idex_rs,
  input  logic [NSRC-1:0]         idex_use,
  input  logic                    exmem_we,
  input  logic [AW-1:0]           exmem_rd,
  input  logic                    memwb_we,
  input  logic [AW-1:0]           memwb_rd,
  output logic [NSRC-1:0][1:0]    ex_sel
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic live, hit_em, hit_mw;
    assign live   = idex_use[g] && (idex_rs[g] != '0);
    assign hit_em = live && exmem_we && (exmem_rd == idex_rs[g]);
    assign hit_mw = live && memwb_we && (memwb_rd == idex_rs[g]);
    always_comb begin
      if (hit_em)      ex_sel[g] = FWD_EXMEM;
      else if (hit_mw) ex_sel[g] = FWD_MEMWB;
      else             ex_sel[g] = FWD_FILE;
    end
  end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                    id_valid,
  input  logic [NSRC-1:0][AW-1:0] id_rs,
  input  logic [NSRC-1:0]         id_use,
  input  logic                    id_branch,
  input  logic                    id_br_taken,
  input  logic                    idex_we,
  input  logic                    idex_load,
  input  logic [AW-1:0]           idex_rd,
  input  logic                    exmem_we,
  input  logic                    exmem_load,
  input  logic [AW-1:0]           exmem_rd,
  output logic [NSRC-1:0]         id_sel,
  output logic                    stall,
  output logic                    bubble,
  output logic                    squash
);
  logic [NSRC-1:0] hold_vec;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic live, m_ex, m_mem;
    assign live  = id_valid && id_use[g] && (id_rs[g] != '0);
    assign m_ex  = live && idex_we && (idex_rd == id_rs[g]);
    assign m_mem = live && exmem_we && (exmem_rd == id_rs[g]);
    // load in execute: any consumer waits; branch in decode waits on any producer in execute
    // and on a load in memory
    assign hold_vec[g] = (m_ex && (idex_load || id_branch)) ||
                         (m_mem && exmem_load && id_branch);
    assign id_sel[g]   = m_mem && !exmem_load && id_branch;
  end

  always_comb begin
    stall  = |hold_vec;
    bubble = stall;
    squash = id_valid && id_branch && id_br_taken && !stall;
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic [AW-1:0] id_rd,
  input  logic          id_we,
  input  logic          id_load,
  input  logic          id_branch,
  input  logic          id_br_taken,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic          id_fwd_a,
  output logic          id_fwd_b,
  output logic          stall,
  output logic          bubble,
  output logic          squash
);
  logic                    rst_sync_n;
  logic [NSRC-1:0][AW-1:0] id_rs_v, idex_rs;
  logic [NSRC-1:0]         id_use_v, idex_use, id_sel;
  logic [NSRC-1:0][1:0]    ex_sel;
  logic                    idex_we, idex_load, exmem_we, exmem_load, memwb_we;
  logic [AW-1:0]           idex_rd, exmem_rd, memwb_rd;

  assign id_rs_v  = {id_rs2, id_rs1};
  assign id_use_v = {id_use_rs2, id_use_rs1};

  hzd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  hzd_track #(.AW(AW), .NSRC(NSRC)) u_track (
    .clk(clk), .rst_n(rst_sync_n), .id_valid(id_valid), .id_we(id_we),
    .id_load(id_load), .id_rd(id_rd), .id_rs(id_rs_v), .id_use(id_use_v),
    .bubble(bubble), .idex_we(idex_we), .idex_load(idex_load), .idex_rd(idex_rd),
    .idex_rs(idex_rs), .idex_use(idex_use), .exmem_we(exmem_we),
    .exmem_load(exmem_load), .exmem_rd(exmem_rd), .memwb_we(memwb_we),
    .memwb_rd(memwb_rd)
  );

  hzd_fwd_sel #(.AW(AW), .NSRC(NSRC)) u_fwd (
    .idex_rs(idex_rs), .idex_use(idex_use), .exmem_we(exmem_we),
    .exmem_rd(exmem_rd), .memwb_we(memwb_we), .memwb_rd(memwb_rd),
    .ex_sel(ex_sel)
  );

  hzd_stall_ctl #(.AW(AW), .NSRC(NSRC)) u_stall (
    .id_valid(id_valid), .id_rs(id_rs_v), .id_use(id_use_v),
    .id_branch(id_branch), .id_br_taken(id_br_taken), .idex_we(idex_we),
    .idex_load(idex_load), .idex_rd(idex_rd), .exmem_we(exmem_we),
    .exmem_load(exmem_load), .exmem_rd(exmem_rd), .id_sel(id_sel),
    .stall(stall), .bubble(bubble), .squash(squash)
  );

  assign ex_fwd_a = ex_sel[0];
  assign ex_fwd_b = ex_sel[1];
  assign id_fwd_a = id_sel[0];
  assign id_fwd_b = id_sel[1];
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          id_valid,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic          id_branch,
  input logic [1:0]    ex_fwd_a,
  input logic [1:0]    ex_fwd_b,
  input logic          stall,
  input logic          bubble,
  input logic          squash
);
  // R12
  bubble_tracks_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall == bubble);

  // R12
  squash_excl_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> !stall);

  // R9
  squash_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (id_valid && id_branch));

  // R7
  zero_src_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0 && id_rs2 == '0) |-> !stall);

  // R10
  double_stall_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> id_branch);

  // R2
  sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a != 2'b11) && (ex_fwd_b != 2'b11));
endmodule

bind hazard_fwd_unit hzd_unit_chk #(.AW(AW)) chk_i (.*);

// File: tb/hazard_fwd_unit_tb_top.sv
module hazard_fwd_unit_tb_top;
  logic       clk, rst_n;
  logic       id_valid, id_use_rs1, id_use_rs2, id_we, id_load, id_branch, id_br_taken;
  logic [4:0] id_rs1, id_rs2, id_rd;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic       id_fwd_a, id_fwd_b, stall, bubble, squash;
  int n_chk, n_bad;
  bit done;

  hazard_fwd_unit dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  // advance one clock; inputs change right after the falling edge, checks 1 ns later
  task automatic cyc();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic put(bit v, logic [4:0] rd, bit we, bit ld,
                     logic [4:0] a, bit ua, logic [4:0] b, bit ub, bit br, bit tk);
    id_valid = v; id_rd = rd; id_we = we; id_load = ld;
    id_rs1 = a; id_use_rs1 = ua; id_rs2 = b; id_use_rs2 = ub;
    id_branch = br; id_br_taken = tk;
    #1;
  endtask

  task automatic nop();          put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic drain();        nop(); cyc(); cyc(); cyc(); endtask

  task automatic t_reset();
    nop();
    rst_n = 1'b0; #45; rst_n = 1'b1;
    cyc(); cyc(); cyc();
    chk("R1 fwd_a", ex_fwd_a, 0); chk("R1 fwd_b", ex_fwd_b, 0);
    chk("R1 id_fwd", {id_fwd_a, id_fwd_b}, 0);
    chk("R1 stall/bubble/squash", {stall, bubble, squash}, 0);
  endtask

  task automatic t_exmem();
    put(1, 1, 1, 0, 2, 1, 3, 1, 0, 0); cyc();
    put(1, 4, 1, 0, 1, 1, 5, 1, 0, 0);
    chk("R2 no stall", stall, 0); cyc();
    nop(); chk("R2 fwd_a exmem", ex_fwd_a, 1); chk("R2 fwd_b file", ex_fwd_b, 0);
    drain();
  endtask

  task automatic t_memwb();
    put(1, 2, 1, 0, 0, 0, 0, 0, 0, 0); cyc();
    nop(); cyc();
    put(1, 6, 1, 0, 7, 1, 2, 1, 0, 0); cyc();
    nop(); chk("R3 fwd_b memwb", ex_fwd_b, 2); chk("R3 fwd_a file", ex_fwd_a, 0);
    drain();
  endtask

  task automatic t_prio();
    put(1, 4, 1, 0, 0, 0, 0, 0, 0, 0); cyc();
    put(1, 4, 1, 0, 0, 0, 0, 0, 0, 0); cyc();
    put(1, 8, 1, 0, 4, 1, 4, 1, 0, 0); cyc();
    nop(); chk("R4 prio a", ex_fwd_a, 1); chk("R4 prio b", ex_fwd_b, 1);
    drain();
  endtask

  task automatic t_third();
    put(1, 3, 1, 0, 0, 0, 0, 0, 0, 0); cyc();
    nop(); cyc(); nop(); cyc();
    put(1, 9, 1, 0, 3, 1, 0, 0, 0, 0);
    chk("R5 no stall", stall, 0); cyc();
    nop(); chk("R5 from file", ex_fwd_a, 0);
    drain();
  endtask

  task automatic t_loaduse();
    put(1, 5, 1, 1, 1, 1, 0, 0, 0, 0); cyc();
    put(1, 10, 1, 0, 5, 1, 0, 0, 0, 0);
    chk("R6 stall", stall, 1); chk("R6 bubble", bubble, 1); cyc();
    chk("R6 single stall", stall, 0); chk("R6 bubble clear", bubble, 0); cyc();
    nop(); chk("R6 bypass after bubble", ex_fwd_a, 2);
    drain();
  endtask

  task automatic t_zero();
    put(1, 0, 1, 1, 0, 0, 0, 0, 0, 0); cyc();
    put(1, 11, 1, 0, 0, 1, 0, 1, 0, 0);
    chk("R7 r0 no stall", stall, 0); cyc();
    nop(); chk("R7 r0 no fwd a", ex_fwd_a, 0); chk("R7 r0 no fwd b", ex_fwd_b, 0);
    drain();
  endtask

  task automatic t_nowe();
    put(1, 6, 0, 1, 0, 0, 0, 0, 0, 0); cyc();
    put(1, 12, 1, 0, 6, 1, 6, 1, 0, 0);
    chk("R8 no stall", stall, 0); cyc();
    nop(); chk("R8 no fwd", ex_fwd_a, 0);
    drain();
  endtask

  task automatic t_unused();
    put(1, 7, 1, 1, 0, 0, 0, 0, 0, 0); cyc();
    put(1, 13, 1, 0, 7, 0, 7, 0, 0, 0);
    chk("R11 no stall", stall, 0); cyc(); cyc();
    nop(); chk("R11 no fwd", {ex_fwd_a, ex_fwd_b}, 0);
    drain();
  endtask

  task automatic t_branch();
    put(1, 0, 0, 0, 1, 1, 2, 1, 1, 1);
    chk("R9 taken squash", squash, 1); chk("R9 no stall", stall, 0); cyc();
    put(1, 0, 0, 0, 1, 1, 2, 1, 1, 0);
    chk("R9 not taken", squash, 0); cyc();
    drain();
  endtask

  task automatic t_br_dep();
    put(1, 8, 1, 0, 0, 0, 0, 0, 0, 0); cyc();
    put(1, 0, 0, 0, 8, 1, 0, 0, 1, 1);
    chk("R10 alu stall", stall, 1); chk("R12 no squash in stall", squash, 0); cyc();
    chk("R10 alu released", stall, 0); chk("R10 id_fwd_a", id_fwd_a, 1);
    chk("R10 squash", squash, 1);
    drain();
    put(1, 9, 1, 1, 0, 0, 0, 0, 0, 0); cyc();
    put(1, 0, 0, 0, 0, 0, 9, 1, 1, 1);
    chk("R10 load stall 1", stall, 1); cyc();
    chk("R10 load stall 2", stall, 1); chk("R12 no squash", squash, 0); cyc();
    chk("R10 load released", stall, 0); chk("R10 id_fwd_b file", id_fwd_b, 0);
    chk("R10 squash after load", squash, 1);
    drain();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exmem();
    t_memwb();
    t_prio();
    t_third();
    t_loaduse();
    t_zero();
    t_nowe();
    t_unused();
    t_branch();
    t_br_dep();
    summary();
  end
endmodule